// File: doc/BRIEF.md
# Tagged IIR Smoothing Filter

This block sits on the stream of conversion results leaving an analog-to-digital converter controller. Every result carries a 4-bit tag naming the converter unit and channel it came from, plus a 12-bit sample. Two independent first-order recursive low-pass lanes watch the stream. Each lane is bound to one tag and has a power-of-two smoothing coefficient chosen by a 3-bit shift code. When a result's tag matches an enabled lane, the lane updates its accumulator and the result leaves the block carrying the smoothed value in place of the raw sample. Every other result leaves unchanged. The output is registered, so each result appears one cycle after it enters.

Each lane is a two-state machine. LANE_EMPTY means the lane holds no history. LANE_TRACK means it holds a running average. The transitions are:
- **seed**: LANE_EMPTY to LANE_TRACK, on the first matching sample. The sample is loaded directly.
- **step**: LANE_TRACK to LANE_TRACK, on each later matching sample. The accumulator moves by (x − y) >> shift.
- **clear**: any state to LANE_EMPTY, on the synchronous clear input.

The accumulator keeps fractional bits below the sample LSB so that small differences are not lost. The lane output is the accumulator rounded back to 12 bits.

Software binds a lane with the tag ((unit + 1) << 3) | channel. The tag value 0xF is reserved and parks a lane. Software disables a lane by writing tag 0xF with shift code 0.

Top module: `tagged_iir_smoother`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, out_valid is 0 and both lanes are in LANE_EMPTY.
- R2: out_valid equals in_valid of the previous cycle, and out_tag equals the in_tag of that previous cycle.
- R3: A result whose tag matches no enabled lane leaves with out_data equal to its in_data, and no lane's state changes.
- R4: A lane is bound by its 4-bit field of cfg_tag (lane i uses bits [4i+3:4i]). The tag is ((unit + 1) << 3) | (channel & 7), truncated to 4 bits. A result matches the lane when in_tag equals that field.
- R5: A matching result that reaches a lane in LANE_EMPTY loads the accumulator with the sample. The sample leaves unchanged and the lane enters LANE_TRACK.
- R6: A matching result that reaches a lane in LANE_TRACK updates the accumulator as acc += ((x << 6) − acc) >>> k. The accumulator carries 6 fractional bits, and k is the lane's 3-bit cfg_code. The output is (acc + 32) >> 6. Codes 1, 2, 3, 4 and 6 give coefficients 2, 4, 8, 16 and 64.
- R7: cfg_code values 0, 5 and 7 disable the lane, so its tag passes through as in R3.
- R8: A lane bound to tag 0xF is disabled, and results tagged 0xF pass through unchanged.
- R9: When both lanes are enabled with the same tag, lane 0 alone filters the result and lane 1 keeps its state.
- R10: A clr pulse with no sample returns both lanes to LANE_EMPTY, so the next matching sample is loaded as in R5.
- R11: A matching sample that arrives in the same cycle as clr seeds its lane as in R5, and the other lane is emptied.
- R12: Lanes bound to different tags keep separate accumulators under interleaved traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both lanes' history |
| in_valid | input | 1 | Result present on in_tag/in_data |
| in_tag | input | 4 | Unit/channel tag of the result |
| in_data | input | 12 | Raw sample |
| cfg_tag | input | 8 | Lane binding tags, 4 bits per lane, lane 0 in the low bits |
| cfg_code | input | 6 | Lane shift codes, 3 bits per lane, lane 0 in the low bits |
| out_valid | output | 1 | Result present on out_tag/out_data |
| out_tag | output | 4 | Tag of the registered result |
| out_data | output | 12 | Filtered or passed-through sample |

## Verification
The bench targets the following corner cases:
- **Seeding.** A lane must load its first sample rather than average it against zero. A design that averaged against zero would show a first output far below the input.
- **Shift-code boundaries.** The bench drives both extreme valid codes. It also drives the invalid codes 0, 5 and 7, which must pass the data through. A design that decoded codes loosely would smooth a stream that should stay raw.
- **Clearing.** The bench clears a lane with no sample present, and again in the same cycle as a matching sample. A design that let the clear lose against the sample would carry stale history forward.
- **Shared tag.** The bench binds both lanes to one tag, then rebinds lane 0 away and sends a sample to lane 1. The first output after the rebind must be raw. A design that advanced both lanes would produce a smoothed value there.

// File: rtl/smth_pkg.sv
package smth_pkg;

    typedef enum logic [0:0] {
        LANE_EMPTY = 1'b0,
        LANE_TRACK = 1'b1
    } lane_state_t;

    // Shift codes that select a coefficient: 1,2,3,4 and 6.
    function automatic logic code_ok(input logic [2:0] code);
        unique case (code)
            3'd1, 3'd2, 3'd3, 3'd4, 3'd6: code_ok = 1'b1;
            default:                      code_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/smth_lane.sv
module smth_lane
    import smth_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 12,
    parameter int FCODE_W = 3,
    parameter int FRAC_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [TAG_W-1:0]   bind_tag,
    input  logic [FCODE_W-1:0] fcode,
    input  logic               smp_valid,
    input  logic [TAG_W-1:0]   smp_tag,
    input  logic [DATA_W-1:0]  smp_data,
    input  logic               claim_ok,
    output logic               match,
    output logic               take,
    output logic [DATA_W-1:0]  result,
    output logic               is_empty
);

    localparam int ACC_W = DATA_W + FRAC_W;
    localparam logic [ACC_W:0] HALF = (ACC_W+1)'(1) << (FRAC_W - 1);
    localparam logic [TAG_W-1:0] TAG_PARK = '1;

    lane_state_t        state_q, state_d, state_eff;
    logic [ACC_W-1:0]   acc_q, acc_d, seed;
    logic signed [ACC_W:0] diff;
    logic               enabled;

    assign enabled = (bind_tag != TAG_PARK) && code_ok(3'(fcode));
    assign match   = enabled && smp_valid && (smp_tag == bind_tag);
    assign take    = match && claim_ok;
    assign seed    = {smp_data, {FRAC_W{1'b0}}};
    assign diff    = $signed({1'b0, seed}) - $signed({1'b0, acc_q});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_EMPTY;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next state: clear wins over history, a coincident sample then seeds.
    always_comb begin
        state_eff = clr ? LANE_EMPTY : state_q;
        state_d   = state_eff;
        acc_d     = acc_q;
        if (take) begin
            unique case (state_eff)
                LANE_EMPTY: begin
                    acc_d   = seed;
                    state_d = LANE_TRACK;
                end
                LANE_TRACK: begin
                    acc_d   = ACC_W'($signed({1'b0, acc_q}) + (diff >>> fcode));
                    state_d = LANE_TRACK;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        is_empty = (state_q == LANE_EMPTY);
        result   = DATA_W'(({1'b0, acc_d} + HALF) >> FRAC_W);
    end

endmodule

// File: rtl/smth_route.sv
module smth_route #(
    parameter int LANES  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [LANES-1:0]         take,
    input  logic [LANES*DATA_W-1:0]  lane_result,
    output logic                     out_valid,
    output logic [TAG_W-1:0]         out_tag,
    output logic [DATA_W-1:0]        out_data
);

    logic [DATA_W-1:0] sel_data;

    always_comb begin
        sel_data = in_data;
        for (int i = 0; i < LANES; i++) begin
            if (take[i]) sel_data = lane_result[i*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_tag   <= in_tag;
            out_data  <= sel_data;
        end
    end

endmodule

// File: rtl/tagged_iir_smoother.sv
module tagged_iir_smoother #(
    parameter int LANES   = 2,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 12,
    parameter int FCODE_W = 3,
    parameter int FRAC_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     in_valid,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [LANES*TAG_W-1:0]   cfg_tag,
    input  logic [LANES*FCODE_W-1:0] cfg_code,
    output logic                     out_valid,
    output logic [TAG_W-1:0]         out_tag,
    output logic [DATA_W-1:0]        out_data
);

    logic [LANES-1:0]        lane_match;
    logic [LANES-1:0]        lane_take;
    logic [LANES-1:0]        lane_claim;
    logic [LANES-1:0]        lane_empty;
    logic [LANES*DATA_W-1:0] lane_result;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_head
            assign lane_claim[g] = 1'b1;
        end else begin : g_tail
            assign lane_claim[g] = lane_claim[g-1] & ~lane_match[g-1];
        end

        smth_lane #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .FCODE_W(FCODE_W),
            .FRAC_W (FRAC_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .bind_tag (cfg_tag[g*TAG_W +: TAG_W]),
            .fcode    (cfg_code[g*FCODE_W +: FCODE_W]),
            .smp_valid(in_valid),
            .smp_tag  (in_tag),
            .smp_data (in_data),
            .claim_ok (lane_claim[g]),
            .match    (lane_match[g]),
            .take     (lane_take[g]),
            .result   (lane_result[g*DATA_W +: DATA_W]),
            .is_empty (lane_empty[g])
        );
    end

    smth_route #(
        .LANES (LANES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_tag     (in_tag),
        .in_data    (in_data),
        .take       (lane_take),
        .lane_result(lane_result),
        .out_valid  (out_valid),
        .out_tag    (out_tag),
        .out_data   (out_data)
    );

endmodule

// File: rtl/smth_checker.sv
module smth_checker #(
    parameter int LANES  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic [TAG_W-1:0]  in_tag,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [TAG_W-1:0]  out_tag,
    input logic [DATA_W-1:0] out_data,
    input logic [LANES-1:0]  take,
    input logic [LANES-1:0]  empty
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_tag_carried_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_tag == $past(in_tag)));

    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (take == '0)) |=> (out_data == $past(in_data)));

    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> (empty == '1));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        p_first_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (take[g] && (empty[g] || clr)) |=> (out_data == $past(in_data)));

        p_seed_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
            take[g] |=> !empty[g]);
    end

endmodule

bind tagged_iir_smoother smth_checker #(
    .LANES (LANES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
) u_smth_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .in_tag   (in_tag),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_tag  (out_tag),
    .out_data (out_data),
    .take     (lane_take),
    .empty    (lane_empty)
);

// File: tb/tagged_iir_smoother_bench.sv
`timescale 1ns/1ps
module tagged_iir_smoother_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_tag = '0;
    logic [11:0] in_data = '0;
    logic [7:0]  cfg_tag = '1;
    logic [5:0]  cfg_code = '0;
    logic        out_valid;
    logic [3:0]  out_tag;
    logic [11:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state
    int acc [2];
    bit full [2];

    always #2 clk = ~clk;

    tagged_iir_smoother u_tagged_iir_smoother (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_tag(in_tag), .in_data(in_data), .cfg_tag(cfg_tag),
        .cfg_code(cfg_code), .out_valid(out_valid), .out_tag(out_tag),
        .out_data(out_data)
    );

    // Stream for the table walk: {tag, data}. Lane 0 on 0x9 (code 2), lane 1 on 0x3 (code 6).
    localparam int NVEC = 16;
    localparam logic [15:0] VEC [NVEC] = '{
        {4'h9, 12'd1000}, {4'h3, 12'd4095}, {4'h5, 12'd77},   {4'h9, 12'd2000},
        {4'h3, 12'd0},    {4'h9, 12'd2000}, {4'hF, 12'd3210}, {4'h3, 12'd0},
        {4'h9, 12'd0},    {4'h9, 12'd4095}, {4'h3, 12'd4095}, {4'h0, 12'd12},
        {4'h9, 12'd1},    {4'h3, 12'd2048}, {4'h9, 12'd3},    {4'h3, 12'd2049}
    };

    function automatic bit lane_on(input int l);
        logic [3:0] t;
        logic [2:0] c;
        t = cfg_tag[l*4 +: 4];
        c = cfg_code[l*3 +: 3];
        return (t != 4'hF) && (c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd4 || c == 3'd6);
    endfunction

    function automatic int model(input logic [3:0] t, input logic [11:0] d, input bit c);
        int owner;
        int x;
        int diff;
        if (c) begin full[0] = 1'b0; full[1] = 1'b0; end
        owner = -1;
        for (int l = 1; l >= 0; l--)
            if (lane_on(l) && t == cfg_tag[l*4 +: 4]) owner = l;
        if (owner < 0) return int'(d);
        x = int'(d) * 64;
        if (!full[owner]) begin
            acc[owner] = x;
            full[owner] = 1'b1;
        end else begin
            diff = x - acc[owner];
            acc[owner] = acc[owner] + (diff >>> int'(cfg_code[owner*3 +: 3]));
        end
        return (acc[owner] + 32) / 64;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] t, input logic [11:0] d, input bit c, input string req);
        int exp;
        @(negedge clk);
        in_valid = 1'b1; in_tag = t; in_data = d; clr = c;
        exp = model(t, d, c);
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
        check(out_valid === 1'b1, {req, " valid (R2)"}, int'(out_valid), 1);
        check(out_tag === t, {req, " tag (R2)"}, int'(out_tag), int'(t));
        check(out_data === 12'(exp), req, int'(out_data), exp);
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        clr = 1'b1;
        void'(model(4'h0, 12'd0, 1'b1) );
        @(negedge clk);
        clr = 1'b0;
        check(out_valid === 1'b0, "R2 idle after clear", int'(out_valid), 0);
    endtask

    initial begin
        full[0] = 1'b0; full[1] = 1'b0; acc[0] = 0; acc[1] = 0;
        cfg_tag = {4'h3, 4'h9};
        cfg_code = {3'd6, 3'd2};
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 after reset out_valid", int'(out_valid), 0);

        // Table walk: R4 binding, R5 seed, R6 step, R3/R8 pass-through, R12 interleave
        for (int i = 0; i < NVEC; i++)
            send(VEC[i][15:12], VEC[i][11:0], 1'b0, "R6 R12 table stream");

        // R7: invalid codes pass through, lane keeps its history
        cfg_code[2:0] = 3'd5;
        send(4'h9, 12'd999, 1'b0, "R7 code 5 passthru");
        cfg_code[2:0] = 3'd7;
        send(4'h9, 12'd10, 1'b0, "R7 code 7 passthru");
        cfg_code[2:0] = 3'd0;
        send(4'h9, 12'd20, 1'b0, "R7 code 0 passthru");
        cfg_code[2:0] = 3'd3;
        send(4'h9, 12'd1600, 1'b0, "R6 code 3 resumes history");
        cfg_code[2:0] = 3'd4;
        send(4'h9, 12'd0, 1'b0, "R6 code 4 step");
        cfg_code[2:0] = 3'd1;
        send(4'h9, 12'd4000, 1'b0, "R6 code 1 step");

        // R8: lane parked on 0xF
        cfg_tag[7:4] = 4'hF; cfg_code[5:3] = 3'd2;
        send(4'hF, 12'd555, 1'b0, "R8 tag F passthru");
        send(4'hF, 12'd5, 1'b0, "R8 tag F passthru again");

        // R10: clear alone, then first sample loads
        clr_pulse();
        send(4'h9, 12'd321, 1'b0, "R10 load after clear");
        send(4'h9, 12'd3000, 1'b0, "R10 step after reload");

        // R11: clear coincident with a sample
        send(4'h9, 12'd50, 1'b1, "R11 clear with sample seeds");
        send(4'h9, 12'd4050, 1'b0, "R11 step from new seed");

        // R9: shared tag, lane 0 owns it and lane 1 stays empty
        cfg_tag = {4'h6, 4'h6}; cfg_code = {3'd1, 3'd1};
        clr_pulse();
        send(4'h6, 12'd1000, 1'b0, "R9 shared seed lane 0");
        send(4'h6, 12'd2000, 1'b0, "R9 shared step lane 0");
        cfg_tag[3:0] = 4'hF;
        send(4'h6, 12'd300, 1'b0, "R9 lane 1 untouched loads raw");
        send(4'h6, 12'd301, 1'b0, "R9 lane 1 steps");

        // R1: reset in mid-stream empties lanes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 reset mid-stream", int'(out_valid), 0);
        rst_n = 1'b1;
        full[0] = 1'b0; full[1] = 1'b0;
        send(4'h6, 12'd4095, 1'b0, "R1 lane empty after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule